// File: doc/BRIEF.md
# Prescaled Serial Clock Generator

This block makes the serial clock for a two-wire bus controller. The input clock is first divided by a programmable prescaler, giving one module-clock tick every (prescaler + 1) input cycles. The serial clock low and high phases are then timed in module ticks. Each phase lasts its programmed 16-bit count plus a fixed extension d. The extension depends on the prescaler value: 7 when it is 0, 6 when it is 1, and 5 when it is 2 or more.

A protocol engine sets the three count inputs while the run control is low. It then raises run and pulses start. The generator first drives a low phase and then alternates low and high phases until run is dropped. The engine gets a one-cycle strobe at every falling and rising edge of the serial clock. It uses these strobes to place its data changes and its sampling. For a module clock in the 7 to 12 MHz range, software picks a prescaler and two counts so that (prescaler + 1) x (low + high + 2d) input cycles gives the wanted bus period.

Top module: `scl_clock_gen`

## Requirements
- R1: While rst_ni is low, or while the generator is idle, scl_o is 1 and fall_o and rise_o are 0.
- R2: When run_i is 1 and the generator is idle, a start_i sampled high at a clock edge makes scl_o go to 0 and fall_o go to 1 in the cycle after that edge. The low phase always comes first.
- R3: Each low phase lasts exactly (low_cnt_i + d) x (psc_i + 1) input clock cycles, measured from its fall strobe to the next rise strobe.
- R4: Each high phase lasts exactly (high_cnt_i + d) x (psc_i + 1) input clock cycles, measured from its rise strobe to the next fall strobe.
- R5: The extension d is 7 for a prescaler of 0, 6 for a prescaler of 1, and 5 for any prescaler of 2 or more.
- R6: A low or high count of 0 gives a phase of exactly d module ticks.
- R7: fall_o is high for one cycle, and only in the first cycle of a low level of scl_o. rise_o is high for one cycle, and only in the first cycle of a high level. The two are never high together.
- R8: A change of low_cnt_i or high_cnt_i made during a run takes effect at the next phase of that kind. The phase in progress keeps its length.
- R9: psc_i is captured at start. A change of psc_i during a run has no effect on phase lengths until the next start.
- R10: When run_i is 0 at a clock edge, the generator is idle in the next cycle: scl_o is 1 and neither strobe is raised. A start_i while run_i is 0 is ignored.
- R11: A start_i that arrives while the generator is already running is ignored, and the phase in progress keeps its length.
- R12: While run_i stays 1, low and high phases alternate without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | 1 lets the generator run, 0 holds it idle |
| start_i | input | 1 | Start request, taken only when idle and run_i is 1 |
| psc_i | input | PSC_W | Prescaler value; module tick every psc_i+1 input cycles |
| low_cnt_i | input | CNT_W | Low phase count, in module ticks before extension |
| high_cnt_i | input | CNT_W | High phase count, in module ticks before extension |
| scl_o | output | 1 | Serial clock level |
| fall_o | output | 1 | One-cycle strobe on a falling scl_o edge |
| rise_o | output | 1 | One-cycle strobe on a rising scl_o edge |

## Verification
The bench sweeps prescaler values 0 to 3 against low and high counts that include 0. This covers each of the three extension values, so a wrong d or a missing (prescaler + 1) factor shows up as a phase length that is off by a computable amount. It changes a count and the prescaler in the middle of a phase. A design that reloads live values would give a runt or stretched phase, and a design that never reloads would keep the old length. It also pulses start during a run and while run is low, and drops run in the middle of a low phase. A design that restarts on a second start, or that fails to return the line high, would show a cut phase or a stuck low level.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_e;

  // phase extension chosen by prescaler setting
  function automatic logic [2:0] phase_offset(input logic psc_zero, input logic psc_one);
    if (psc_zero)     return 3'd7;
    else if (psc_one) return 3'd6;
    else              return 3'd5;
  endfunction
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PSC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             en_i,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
      cnt_q <= '0;
    end else if (clear_i) begin
      psc_q <= psc_i;
      cnt_q <= '0;
    end else if (en_i) begin
      cnt_q <= (cnt_q == psc_q) ? '0 : cnt_q + 1'b1;
    end
  end

  assign tick_o = en_i && (cnt_q == psc_q);

  p_cnt_in_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= psc_q);
  p_psc_held_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> $stable(psc_q));
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int CNT_W = 16,
  localparam int LD_W = CNT_W + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [LD_W-1:0] load_val_i,
  input  logic            tick_i,
  output logic            done_o
);
  logic [LD_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            rem_q <= '0;
    else if (load_i)        rem_q <= load_val_i;
    else if (tick_i && rem_q != '0) rem_q <= rem_q - 1'b1;
  end

  assign done_o = tick_i && (rem_q == '0);

  p_rem_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !tick_i) |=> $stable(rem_q));
  p_no_underflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && rem_q == '0) |-> load_i);
endmodule

// File: rtl/scl_clock_gen.sv
module scl_clock_gen
  import sclgen_pkg::*;
#(
  parameter int PSC_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] low_cnt_i,
  input  logic [CNT_W-1:0] high_cnt_i,
  output logic             scl_o,
  output logic             fall_o,
  output logic             rise_o
);
  localparam int LD_W = CNT_W + 1;

  phase_e          phase_q;
  logic            scl_q, fall_q, rise_q;
  logic [2:0]      d_q, d_live, d_use;
  logic            busy, start_go, tick, done, boundary, load;
  logic [CNT_W-1:0] next_cnt;
  logic [LD_W-1:0]  load_val;

  assign busy     = (phase_q != PH_IDLE);
  assign start_go = run_i && !busy && start_i;
  assign boundary = run_i && busy && done;
  assign load     = start_go || boundary;
  assign d_live   = phase_offset(psc_i == '0, psc_i == PSC_W'(1));
  assign d_use    = start_go ? d_live : d_q;
  // low first after start; otherwise the phase opposite to the current one
  assign next_cnt = (start_go || phase_q == PH_HIGH) ? low_cnt_i : high_cnt_i;
  assign load_val = {1'b0, next_cnt} + LD_W'(d_use) - LD_W'(1);

  scl_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(start_go),
    .psc_i  (psc_i),
    .en_i   (run_i && busy),
    .tick_o (tick)
  );

  scl_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .tick_i    (tick),
    .done_o    (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      scl_q   <= 1'b1;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
      d_q     <= 3'd7;
    end else if (!run_i) begin
      phase_q <= PH_IDLE;
      scl_q   <= 1'b1;
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end else if (start_go) begin
      phase_q <= PH_LOW;
      scl_q   <= 1'b0;
      fall_q  <= 1'b1;
      rise_q  <= 1'b0;
      d_q     <= d_live;
    end else if (boundary) begin
      phase_q <= (phase_q == PH_LOW) ? PH_HIGH : PH_LOW;
      scl_q   <= (phase_q == PH_LOW);
      fall_q  <= (phase_q == PH_HIGH);
      rise_q  <= (phase_q == PH_LOW);
    end else begin
      fall_q  <= 1'b0;
      rise_q  <= 1'b0;
    end
  end

  assign scl_o  = scl_q;
  assign fall_o = fall_q;
  assign rise_o = rise_q;

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_IDLE) |-> (scl_q && !fall_q && !rise_q));
  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_go |=> (fall_q && !scl_q));
  p_fall_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> (!scl_q && $past(scl_q)));
  p_rise_edge_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> (scl_q && !$past(scl_q)));
  p_one_strobe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fall_q && rise_q));
  p_run_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (scl_q && !fall_q && !rise_q));
  p_busy_start_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && run_i && !done) |=> $stable(scl_q));
endmodule

// File: tb/sim_scl_clock_gen.sv
module sim_scl_clock_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  psc = '0;
  logic [15:0] low_c = '0;
  logic [15:0] high_c = '0;
  logic        scl, fall, rise;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  scl_clock_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .start_i(start),
    .psc_i(psc), .low_cnt_i(low_c), .high_cnt_i(high_c),
    .scl_o(scl), .fall_o(fall), .rise_o(rise)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dext(input int p);
    return (p == 0) ? 7 : (p == 1) ? 6 : 5;
  endfunction

  // count negedges until the wanted strobe; flag strobe/level misbehaviour
  task automatic wait_strobe(output int n, output int bad, input bit want_rise, input int poke_at);
    n = 0; bad = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      n++;
      start = (n == poke_at);
      if (fall && rise) bad++;
      if (want_rise ? fall : rise) bad++;
      if (want_rise ? rise : fall) begin
        if (scl != want_rise) bad++;
        start = 1'b0;
        return;
      end
    end
    n = -1;
    start = 1'b0;
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(fall && !scl && !rise, "R2 start gives low phase and fall strobe", int'(scl), 0);
  endtask

  task automatic stop_run();
    @(negedge clk); run = 1'b0;
    @(negedge clk);
    chk(scl && !fall && !rise, "R10 run low returns line high", int'(scl), 1);
    run = 1'b1;
  endtask

  initial begin
    int n, bad, exp_l, exp_h;
    repeat (3) @(negedge clk);
    chk(scl && !fall && !rise, "R1 reset state", int'(scl), 1);
    rst_n = 1'b1;
    run = 1'b1;
    repeat (3) @(negedge clk);
    chk(scl && !fall && !rise, "R1 idle after reset", int'(scl), 1);

    // sweep prescaler and counts (R3 R4 R5 R6 R12)
    for (int p = 0; p < 4; p++) begin
      for (int li = 0; li < 3; li++) begin
        for (int hi = 0; hi < 3; hi++) begin
          psc = 8'(p);
          low_c  = 16'((li == 0) ? 0 : (li == 1) ? 1 : 4);
          high_c = 16'((hi == 0) ? 0 : (hi == 1) ? 2 : 3);
          exp_l = (int'(low_c) + dext(p)) * (p + 1);
          exp_h = (int'(high_c) + dext(p)) * (p + 1);
          do_start();
          wait_strobe(n, bad, 1'b1, -1);
          chk(n == exp_l, (low_c == 0) ? "R6 zero low count" : "R3 R5 low phase length", n, exp_l);
          chk(bad == 0, "R7 strobe and level consistency", bad, 0);
          wait_strobe(n, bad, 1'b0, -1);
          chk(n == exp_h, (high_c == 0) ? "R6 zero high count" : "R4 R5 high phase length", n, exp_h);
          wait_strobe(n, bad, 1'b1, -1);
          chk(n == exp_l && bad == 0, "R12 second low phase", n, exp_l);
          stop_run();
        end
      end
    end

    // R8 count change mid-phase
    psc = 8'd2; low_c = 16'd3; high_c = 16'd3;
    do_start();
    low_c = 16'd0;
    wait_strobe(n, bad, 1'b1, -1);
    chk(n == 24, "R8 current low phase keeps old count", n, 24);
    wait_strobe(n, bad, 1'b0, -1);
    chk(n == 24, "R8 high phase unaffected", n, 24);
    wait_strobe(n, bad, 1'b1, -1);
    chk(n == 15, "R8 next low phase uses new count", n, 15);
    stop_run();

    // R9 prescaler change during run
    psc = 8'd2; low_c = 16'd3; high_c = 16'd3;
    do_start();
    psc = 8'd0;
    wait_strobe(n, bad, 1'b1, -1);
    chk(n == 24, "R9 prescaler held for low phase", n, 24);
    wait_strobe(n, bad, 1'b0, -1);
    chk(n == 24, "R9 prescaler held for high phase", n, 24);
    stop_run();

    // R11 start during high phase
    psc = 8'd1; low_c = 16'd2; high_c = 16'd4;
    do_start();
    wait_strobe(n, bad, 1'b1, -1);
    chk(n == 16, "R11 low phase before poke", n, 16);
    wait_strobe(n, bad, 1'b0, 3);
    chk(n == 20 && bad == 0, "R11 start while busy ignored", n, 20);

    // R10 drop run mid low phase, then start while run low
    repeat (4) @(negedge clk);
    stop_run();
    run = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!scl || fall || rise) n++;
    end
    chk(n == 0, "R10 start ignored while run low", n, 0);
    chk(scl == 1'b1, "R1 idle line high", int'(scl), 1);

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule